// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block turns one command into one complete time slot on an open-drain single-wire bus. It pulls the line low for a set time, lets it go, samples the line at a fixed point when the slot calls for it, and then waits out the rest of the slot. Four slots are available: writing a 0, writing a 1, reading a bit, and a bus reset that checks whether any device answered.

A free-running prescaler turns the system clock into a one-microsecond tick. Every slot interval is a whole number of these ticks, multiplied by a scale value captured when the command is accepted. A controller above this block issues one command, waits for the done pulse and reads the returned bit. It builds bytes, searches and checksums out of these slots.

Top module: `slot_timer`

## Requirements
- R1: An interval of N microseconds lasts N × k × CLK_PER_US clock cycles, where k is the `scale` input captured with the command. A scale of 0 acts as 1.
- R2: A write-1 slot (`cmd` = 2'b01) pulls the line low for 6 µs and ends 70 µs after the start. Its result is 1.
- R3: A write-0 slot (`cmd` = 2'b00) pulls the line low for 60 µs and ends 70 µs after the start. Its result is 0.
- R4: A read slot (`cmd` = 2'b10) pulls the line low for 6 µs and samples the line 9 µs after release. It ends 70 µs after the start. Its result is the sampled level.
- R5: A reset slot (`cmd` = 2'b11) pulls the line low for 500 µs and samples the line 70 µs after release. It ends 430 µs after the sample. Its result is 0 when a device held the line low (presence) and 1 otherwise.
- R6: A `start` seen while `busy` is high is ignored. This includes the last busy cycle. The slot under way keeps its timing and result, and no second slot follows.
- R7: `done` is a single-cycle pulse in the first cycle after `busy` falls. `result` changes only together with `done` and holds until the next slot completes.
- R8: `line_drive_o` is high only during the low phase of a slot. After reset the block is idle with `busy`, `done`, `line_drive_o` and `result` all 0.
- R9: A `start` given in the cycle where `done` is high is accepted at once, so slots can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a slot; taken only when idle |
| cmd | input | 2 | Slot type: 00 write-0, 01 write-1, 10 read, 11 reset |
| scale | input | SCALE_W | Interval multiplier; 0 is treated as 1 |
| line_i | input | 1 | Level of the bus line (asynchronous) |
| line_drive_o | output | 1 | 1 pulls the line low; 0 releases it |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse at slot end |
| result | output | 1 | Sampled bit, presence result, or written bit |

## Verification
Two events can meet at the edge where a slot ends: the end of the running slot and a new start request. A request held in the last busy cycle must be dropped. A request held in the cycle that shows `done` must start the next slot with no idle gap. The bench places `start` at each of these two positions next to the same slot end. It judges the outcome from `busy` in the following cycles and from the low time and total time of the slot that follows.

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int CLK_PER_US = 50,
  parameter int SCALE_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cmd,
  input  logic [SCALE_W-1:0] scale,
  input  logic               line_i,
  output logic               line_drive_o,
  output logic               busy,
  output logic               done,
  output logic               result
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int BASE_W = 10;
  localparam int CNT_W = BASE_W + SCALE_W;

  typedef enum logic [1:0] {IDLE, LOW, GAP, TAIL} phase_t;

  phase_t             ph;
  logic [1:0]         op;
  logic [SCALE_W-1:0] k;
  logic [CNT_W-1:0]   cnt;
  logic [PRE_W-1:0]   pre;
  logic               s1, s2, samp;
  logic               tick;

  function automatic logic [BASE_W-1:0] dur(input logic [1:0] c, input phase_t p);
    case (c)
      2'b00:   return (p == LOW) ? 10'd60  : 10'd5;
      2'b11:   return (p == LOW) ? 10'd500 : (p == GAP) ? 10'd70 : 10'd430;
      default: return (p == LOW) ? 10'd6   : (p == GAP) ? 10'd9  : 10'd55;
    endcase
  endfunction

  wire [SCALE_W-1:0] k_in = (scale == '0) ? SCALE_W'(1) : scale;

  assign tick         = (pre == PRE_W'(CLK_PER_US - 1));
  assign line_drive_o = (ph == LOW);
  assign busy         = (ph != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= IDLE;
      op     <= 2'b00;
      k      <= '0;
      cnt    <= '0;
      pre    <= '0;
      samp   <= 1'b0;
      done   <= 1'b0;
      result <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == IDLE) begin
        pre <= '0;
        if (start) begin
          op  <= cmd;
          k   <= k_in;
          ph  <= LOW;
          cnt <= CNT_W'(dur(cmd, LOW)) * CNT_W'(k_in);
        end
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (cnt == CNT_W'(1)) begin
            case (ph)
              LOW: begin
                ph  <= GAP;
                cnt <= CNT_W'(dur(op, GAP)) * CNT_W'(k);
              end
              GAP: begin
                ph   <= TAIL;
                cnt  <= CNT_W'(dur(op, TAIL)) * CNT_W'(k);
                samp <= s2;
              end
              default: begin
                ph     <= IDLE;
                done   <= 1'b1;
                result <= op[1] ? samp : op[0];
              end
            endcase
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/slot_timer_chk.sv
module slot_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic line_drive_o,
  input logic result
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  // R8
  drive_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) line_drive_o |-> busy);
  // R6
  accept_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R8
  drive_starts_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> line_drive_o);
endmodule

bind slot_timer slot_timer_chk u_chk (.*);

// File: tb/slot_timer_bench.sv
module slot_timer_bench;
  localparam int P = 2;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [SW-1:0] scale = '0;
  logic slave_en = 1'b0;
  logic line_i;
  logic line_drive_o, busy, done, result;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;
  assign line_i = ~(line_drive_o | slave_en);

  slot_timer #(.CLK_PER_US(P), .SCALE_W(SW)) u_slot_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .scale(scale),
    .line_i(line_i), .line_drive_o(line_drive_o), .busy(busy),
    .done(done), .result(result));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [1:0] c);
    case (c)
      2'b00: return "R3";
      2'b01: return "R2";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // entered at a negedge; poke: cycle index at which a stray start is raised
  task automatic run(input logic [1:0] c, input int s, input bit sl,
                     input int poke, input bit b2b);
    int lo, tot, keff, n, lowc, expr;
    keff = (s == 0) ? 1 : s;
    lo  = (c == 2'b11) ? 500 : (c == 2'b00) ? 60 : 6;
    tot = (c == 2'b11) ? 1000 : 70;
    expr = (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : (sl ? 0 : 1);
    cmd = c; scale = SW'(s); slave_en = sl; start = 1'b1;
    n = 0; lowc = 0;
    forever begin
      @(negedge clk);
      n++;
      start = (n == poke);
      if (line_drive_o) lowc++;
      if (done || n > 100000) break;
    end
    chk({tag(c), "/R1 low time"}, lowc, lo * keff * P);
    chk({tag(c), "/R1 slot length"}, n, tot * keff * P + 1);
    chk({tag(c), " result"}, int'(result), expr);
    if (!b2b) begin
      @(negedge clk);
      chk("R7 done single pulse", int'(done), 0);
      chk("R6 no restart after slot", int'(busy), 0);
      chk("R7 result held", int'(result), expr);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset drive", int'(line_drive_o), 0);
    chk("R8 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int sl = 0; sl < 2; sl++)
          run(2'(c), s, sl[0], 0, 1'b0);
    // R6: start in middle of slot and in last busy cycle are ignored
    run(2'b10, 2, 1'b1, 9, 1'b0);
    run(2'b01, 1, 1'b0, 70 * P, 1'b0);
    run(2'b11, 1, 1'b1, 570 * P, 1'b0);
    // R9: back-to-back starts in the done cycle
    run(2'b00, 1, 1'b0, 0, 1'b1);
    run(2'b10, 2, 1'b0, 0, 1'b1);
    run(2'b11, 0, 1'b1, 0, 1'b1);
    chk("R9 chain ended idle", int'(busy), 0);
    run(2'b01, 3, 1'b0, 0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule